// File: doc/BRIEF.md
# Configurable memory wait-state generator

This block times CPU bus accesses. An access is described by a 4-bit region number (address bits 27:24), an access width and a sequential flag. The block looks up the wait count for that region and width, holds `busy_o` for the base cost plus that wait, and then raises `done_o` for one cycle. A load has a base cost of 2 cycles and a store a base cost of 1.

A 16-bit control register, written through a one-cycle write strobe and readable at all times, selects the timing of three cartridge ROM windows and of the save-RAM window. Each ROM window has its own first-access and sequential-access selections and covers two regions (a base region and its mirror). 32-bit costs are built from two 16-bit halves. The block also reports two values for the region on `region_i`: the prefetch cost and the cycle count of a sequential burst of 32-bit words.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0. A write (`cfg_we_i` high at a clock edge) stores all 16 bits of `cfg_wdata_i`, and `cfg_rdata_o` shows them from the next cycle. Without a write the value holds.
- R2: The first-access field of window 0 is bits 3:2, of window 1 bits 6:5 and of window 2 bits 9:8. Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 wait cycles for a non-sequential 8-bit or 16-bit access.
- R3: The sequential bits are bit 4 for window 0, bit 7 for window 1 and bit 10 for window 2. Bit value 1 gives 1 wait cycle in every window. Bit value 0 gives 2 waits in window 0, 4 in window 1 and 8 in window 2. This applies to sequential 8-bit and 16-bit accesses.
- R4: `width_i` encodes 0 as 8 bits, 1 as 16 bits and 2 as 32 bits; code 3 is treated as 16 bits. For a ROM window, the 32-bit first-access wait is the 16-bit first wait plus 1 plus the 16-bit sequential wait, and the 32-bit sequential wait is twice the 16-bit sequential wait plus 1.
- R5: Region 14 (save RAM) uses bits 1:0 with the same 4/3/2/8 mapping. That wait w applies to both first and sequential 8-bit and 16-bit accesses, and its 32-bit wait is 2w+1.
- R6: Region 2 has 2 waits for 8-bit and 16-bit accesses and 5 waits for 32-bit accesses, whether sequential or not. Regions 0, 1, 3 to 7 and 15 have 0 waits.
- R7: An accepted access holds `busy_o` for 2+wait cycles if it is a load (`store_i`=0) or for 1+wait cycles if it is a store. `done_o` is high for exactly the one cycle after `busy_o` falls. A `req_i` while `busy_o` is high is ignored.
- R8: For region `region_i`, `burst_cycles_o` equals (1 + 32-bit first wait) + (N−1) × (1 + 32-bit sequential wait), where N = `burst_len_i`. It is 0 when N = 0.
- R9: `pf_wait_o` is the prefetch cost of `region_i` at `width_i`. For regions 8 to 13 it is 0 when bit 14 is set and equal to the sequential wait of that width when bit 14 is clear. For every other region it equals the region's sequential wait.
- R10: Regions 8/9, 10/11 and 12/13 are the mirror pairs of windows 0, 1 and 2. Both regions of a pair give identical access, prefetch and burst timing.
- R11: A control write takes effect from the next access accepted. An access already holding `busy_o` keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Current control register value |
| req_i | input | 1 | Start an access (accepted when idle) |
| region_i | input | 4 | Region number, address bits 27:24 |
| width_i | input | 2 | Access width code (0: 8, 1: 16, 2: 32 bits) |
| seq_i | input | 1 | Access is sequential |
| store_i | input | 1 | Access is a store (otherwise a load) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse after the access ends |
| pf_wait_o | output | 5 | Prefetch cost for region_i and width_i |
| burst_len_i | input | 5 | Number of 32-bit words in a burst |
| burst_cycles_o | output | 12 | Cycle count of that burst in region_i |

## Verification
The case that is hardest to reach from the ports is a control write that lands while an access is still stalling. The access must keep its old length, and the new timing must first appear on the following access. The stimulus starts a long window-0 load, changes the window-0 code in the middle of the stall, and then expects the old length followed by the new one. A second hard case is a request raised during a stall with a very different cost. Only one completion may come out, with the first access's length, and `busy_o` must stay low afterwards.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int WAIT_W = 5;
  localparam int CFG_W  = 16;
  localparam int N_WIN  = 3;

  localparam int SRAM_LSB = 0;
  localparam int WIN_LSB  = 2;
  localparam int WIN_STEP = 3;
  localparam int PF_BIT   = 14;

  localparam logic [3:0] REG_XRAM = 4'd2;
  localparam logic [3:0] REG_ROM0 = 4'd8;
  localparam logic [3:0] REG_ROMN = 4'd13;
  localparam logic [3:0] REG_SRAM = 4'd14;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_RS = 2'd3
  } width_e;

  typedef struct packed {
    logic [WAIT_W-1:0] n16;
    logic [WAIT_W-1:0] s16;
    logic [WAIT_W-1:0] n32;
    logic [WAIT_W-1:0] s32;
    logic [WAIT_W-1:0] p16;
    logic [WAIT_W-1:0] p32;
  } timing_t;

  localparam timing_t ZERO_T = '0;
  localparam timing_t XRAM_T = '{n16: 5'd2, s16: 5'd2, n32: 5'd5, s32: 5'd5,
                                 p16: 5'd2, p32: 5'd5};

  function automatic logic [WAIT_W-1:0] code_to_wait(input logic [1:0] code);
    case (code)
      2'd0:    code_to_wait = 5'd4;
      2'd1:    code_to_wait = 5'd3;
      2'd2:    code_to_wait = 5'd2;
      default: code_to_wait = 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
  import ws_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CFG_W-1:0]           wdata_i,
  output logic [CFG_W-1:0]           cfg_o,
  output timing_t [N_WIN-1:0]        win_o,
  output timing_t                    sram_o
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [CFG_W-1:0] cfg_q;
  logic             pf_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;
  assign pf_en = cfg_q[PF_BIT];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    logic [1:0]        first_code;
    logic              seq_fast;
    logic [WAIT_W-1:0] n16, s16;

    assign first_code = cfg_q[WIN_LSB + WIN_STEP*w +: 2];
    assign seq_fast   = cfg_q[WIN_LSB + WIN_STEP*w + 2];
    assign n16        = code_to_wait(first_code);
    assign s16        = seq_fast ? ONE : WAIT_W'(2 << w);

    assign win_o[w].n16 = n16;
    assign win_o[w].s16 = s16;
    assign win_o[w].n32 = n16 + ONE + s16;
    assign win_o[w].s32 = (s16 << 1) + ONE;
    assign win_o[w].p16 = pf_en ? '0 : s16;
    assign win_o[w].p32 = pf_en ? '0 : ((s16 << 1) + ONE);
  end

  logic [WAIT_W-1:0] sw, sw32;
  assign sw   = code_to_wait(cfg_q[SRAM_LSB +: 2]);
  assign sw32 = (sw << 1) + ONE;
  assign sram_o = '{n16: sw, s16: sw, n32: sw32, s32: sw32, p16: sw, p32: sw32};

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == $past(wdata_i)); // R1
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q)); // R1
endmodule

// File: rtl/ws_lut.sv
module ws_lut
  import ws_pkg::*;
#(
  parameter int REGION_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REGION_W-1:0] region_i,
  input  logic [1:0]          width_i,
  input  logic                seq_i,
  input  timing_t [N_WIN-1:0] win_i,
  input  timing_t             sram_i,
  output logic [WAIT_W-1:0]   wait_o,
  output logic [WAIT_W-1:0]   pf_o,
  output logic [WAIT_W-1:0]   n32_o,
  output logic [WAIT_W-1:0]   s32_o
);
  localparam int WIDX_W = $clog2(N_WIN);

  timing_t           sel;
  logic              wide;
  logic [REGION_W-1:0] rel;
  logic [WIDX_W-1:0] widx;

  // mirror pair shares one window: drop the low region bit
  assign rel  = region_i - REGION_W'(REG_ROM0);
  assign widx = WIDX_W'(rel >> 1);

  always_comb begin
    sel = ZERO_T;
    if (region_i == REGION_W'(REG_XRAM)) begin
      sel = XRAM_T;
    end else if (region_i >= REGION_W'(REG_ROM0) && region_i <= REGION_W'(REG_ROMN)) begin
      sel = win_i[widx];
    end else if (region_i == REGION_W'(REG_SRAM)) begin
      sel = sram_i;
    end
  end

  assign wide   = (width_e'(width_i) == WID_32);
  assign wait_o = seq_i ? (wide ? sel.s32 : sel.s16) : (wide ? sel.n32 : sel.n16);
  assign pf_o   = wide ? sel.p32 : sel.p16;
  assign n32_o  = sel.n32;
  assign s32_o  = sel.s32;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_i == '1) |-> (wait_o == '0 && pf_o == '0 && n32_o == '0)); // R6
  AST_XRAM_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_i == REGION_W'(REG_XRAM)) |-> (wait_o == (wide ? 5'd5 : 5'd2))); // R6
endmodule

// File: rtl/ws_burst.sv
module ws_burst
  import ws_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int CYC_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BURST_W-1:0] len_i,
  input  logic [WAIT_W-1:0]  n32_i,
  input  logic [WAIT_W-1:0]  s32_i,
  output logic [CYC_W-1:0]   cycles_o
);
  logic [CYC_W-1:0] first_cost, step_cost, rest_cnt, rest_cost;

  assign first_cost = CYC_W'(n32_i) + CYC_W'(1);
  assign step_cost  = CYC_W'(s32_i) + CYC_W'(1);
  assign rest_cnt   = CYC_W'(len_i - BURST_W'(1));
  assign rest_cost  = rest_cnt * step_cost;
  assign cycles_o   = (len_i == '0) ? '0 : (first_cost + rest_cost);

  AST_BURST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i == '0) |-> (cycles_o == '0)); // R8
  AST_BURST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i == BURST_W'(1)) |-> (cycles_o == CYC_W'(n32_i) + CYC_W'(1))); // R8
endmodule

// File: rtl/ws_seq.sv
module ws_seq
  import ws_pkg::*;
#(
  parameter int CYC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              store_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              busy_o,
  output logic              done_o
);
  logic             active_q, done_q;
  logic [CYC_W-1:0] cnt_q, total;

  assign total = CYC_W'(wait_i) + (store_i ? CYC_W'(1) : CYC_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CYC_W'(1);
        end
      end else if (req_i) begin
        // length latched at start; later config writes do not reach it
        active_q <= 1'b1;
        cnt_q    <= total - CYC_W'(1);
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R7
  AST_LEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0) |=> (active_q && cnt_q == $past(cnt_q) - CYC_W'(1))); // R11
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import ws_pkg::*;
#(
  parameter int REGION_W = 4,
  parameter int BURST_W  = 5,
  parameter int CYC_W    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic [CFG_W-1:0]    cfg_rdata_o,
  input  logic                req_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic [1:0]          width_i,
  input  logic                seq_i,
  input  logic                store_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [WAIT_W-1:0]   pf_wait_o,
  input  logic [BURST_W-1:0]  burst_len_i,
  output logic [CYC_W-1:0]    burst_cycles_o
);
  timing_t [N_WIN-1:0] win_t;
  timing_t             sram_t;
  logic [WAIT_W-1:0]   acc_wait, n32, s32;

  ws_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_rdata_o),
    .win_o   (win_t),
    .sram_o  (sram_t)
  );

  ws_lut #(.REGION_W(REGION_W)) u_lut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .region_i (region_i),
    .width_i  (width_i),
    .seq_i    (seq_i),
    .win_i    (win_t),
    .sram_i   (sram_t),
    .wait_o   (acc_wait),
    .pf_o     (pf_wait_o),
    .n32_o    (n32),
    .s32_o    (s32)
  );

  ws_burst #(.BURST_W(BURST_W), .CYC_W(CYC_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_i    (burst_len_i),
    .n32_i    (n32),
    .s32_i    (s32),
    .cycles_o (burst_cycles_o)
  );

  ws_seq #(.CYC_W(CYC_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .store_i (store_i),
    .wait_i  (acc_wait),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  AST_PF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[PF_BIT] && region_i >= REGION_W'(REG_ROM0) && region_i <= REGION_W'(REG_ROMN))
      |-> (pf_wait_o == '0)); // R9
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && req_i && $past(busy_o) && $past(busy_o)) |=> (busy_o || done_o)); // R7
endmodule

// File: tb/wait_state_gen_test.sv
module wait_state_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        req_i = 1'b0;
  logic [3:0]  region_i = '0;
  logic [1:0]  width_i = '0;
  logic        seq_i = 1'b0;
  logic        store_i = 1'b0;
  logic        busy_o, done_o;
  logic [4:0]  pf_wait_o;
  logic [4:0]  burst_len_i = '0;
  logic [11:0] burst_cycles_o;

  int tests = 0;
  int fails = 0;
  int busy_cnt = 0;
  int exp_q[$];
  string tag_q[$];
  logic [15:0] cfg_m = '0;

  always #5 clk_i = ~clk_i;

  wait_state_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .req_i(req_i), .region_i(region_i), .width_i(width_i),
    .seq_i(seq_i), .store_i(store_i), .busy_o(busy_o), .done_o(done_o),
    .pf_wait_o(pf_wait_o), .burst_len_i(burst_len_i), .burst_cycles_o(burst_cycles_o)
  );

  typedef struct { int n16; int s16; int n32; int s32; } tm_t;

  function automatic int first_wait(input int code);
    int tbl[4] = '{4, 3, 2, 8};
    return tbl[code];
  endfunction

  function automatic tm_t model(input logic [15:0] c, input int r);
    tm_t t;
    t.n16 = 0; t.s16 = 0; t.n32 = 0; t.s32 = 0;
    if (r == 2) begin
      t.n16 = 2; t.s16 = 2; t.n32 = 5; t.s32 = 5;
    end else if (r >= 8 && r <= 13) begin
      int w = (r - 8) / 2;
      int slow;
      slow = (w == 0) ? 2 : ((w == 1) ? 4 : 8);
      t.n16 = first_wait(int'(c[2 + 3*w +: 2]));
      t.s16 = c[4 + 3*w] ? 1 : slow;
      t.n32 = t.n16 + t.s16 + 1;
      t.s32 = 2 * t.s16 + 1;
    end else if (r == 14) begin
      t.n16 = first_wait(int'(c[1:0]));
      t.s16 = t.n16;
      t.n32 = 2 * t.n16 + 1;
      t.s32 = t.n32;
    end
    return t;
  endfunction

  function automatic int acc_len(input logic [15:0] c, input int r, input int wid,
                                 input bit sq, input bit st);
    tm_t t = model(c, r);
    int w;
    if (wid == 2) w = sq ? t.s32 : t.n32;
    else          w = sq ? t.s16 : t.n16;
    return (st ? 1 : 2) + w;
  endfunction

  function automatic int pf_model(input logic [15:0] c, input int r, input int wid);
    tm_t t = model(c, r);
    if (r >= 8 && r <= 13 && c[14]) return 0;
    return (wid == 2) ? t.s32 : t.s16;
  endfunction

  function automatic int burst_model(input logic [15:0] c, input int r, input int n);
    tm_t t = model(c, r);
    if (n == 0) return 0;
    return (1 + t.n32) + (n - 1) * (1 + t.s32);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure busy length, compare at done
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o) busy_cnt++;
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", busy_cnt, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(busy_cnt == e, t, busy_cnt, e);
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    cfg_m = v;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic access(input int r, input int wid, input bit sq, input bit st, input string tag);
    exp_q.push_back(acc_len(cfg_m, r, wid, sq, st));
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b1; region_i = 4'(r); width_i = 2'(wid); seq_i = sq; store_i = st;
    @(negedge clk_i);
    req_i = 1'b0;
    wait_done();
  endtask

  task automatic comb_check(input int r, input int wid, input int n, input string tpf, input string tb);
    int e;
    @(negedge clk_i);
    region_i = 4'(r); width_i = 2'(wid); burst_len_i = 5'(n);
    #1;
    e = pf_model(cfg_m, r, wid);
    check(int'(pf_wait_o) == e, tpf, int'(pf_wait_o), e);
    e = burst_model(cfg_m, r, n);
    check(int'(burst_cycles_o) == e, tb, int'(burst_cycles_o), e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cfg_rdata_o == 16'h0, "R1 reset cfg", int'(cfg_rdata_o), 0);
    check(busy_o == 1'b0 && done_o == 1'b0, "R7 reset idle", int'(busy_o), 0);

    cfg_write(16'h5A3C);
    check(cfg_rdata_o == 16'h5A3C, "R1 readback", int'(cfg_rdata_o), 16'h5A3C);
    repeat (2) @(negedge clk_i);
    check(cfg_rdata_o == 16'h5A3C, "R1 hold", int'(cfg_rdata_o), 16'h5A3C);

    // first-access codes in every window
    for (int code = 0; code < 4; code++) begin
      cfg_write(16'((code << 2) | (code << 5) | (code << 8)));
      access(8,  1, 1'b0, 1'b0, "R2 window0 first");
      access(10, 0, 1'b0, 1'b0, "R2 window1 first");
      access(12, 1, 1'b0, 1'b0, "R2 window2 first");
    end

    // sequential bits, both values
    for (int b = 0; b < 2; b++) begin
      cfg_write(16'((b << 4) | (b << 7) | (b << 10) | (1 << 2) | (2 << 5) | (3 << 8)));
      access(8,  1, 1'b1, 1'b0, "R3 window0 seq");
      access(10, 1, 1'b1, 1'b0, "R3 window1 seq");
      access(12, 0, 1'b1, 1'b0, "R3 window2 seq");
      access(8,  2, 1'b0, 1'b0, "R4 window0 32 first");
      access(11, 2, 1'b1, 1'b0, "R4 window1 32 seq");
      access(13, 2, 1'b0, 1'b0, "R4 window2 32 first");
      access(12, 3, 1'b0, 1'b0, "R4 width code 3");
    end

    // save RAM
    for (int code = 0; code < 4; code++) begin
      cfg_write(16'(code));
      access(14, 1, 1'b0, 1'b0, "R5 sram first");
      access(14, 0, 1'b1, 1'b1, "R5 sram seq store");
      access(14, 2, 1'b1, 1'b0, "R5 sram 32");
    end

    // fixed regions
    access(2, 1, 1'b0, 1'b0, "R6 region2 16");
    access(2, 2, 1'b1, 1'b0, "R6 region2 32");
    access(0, 2, 1'b0, 1'b0, "R6 region0");
    access(3, 1, 1'b0, 1'b1, "R6 region3 store");
    access(7, 2, 1'b1, 1'b0, "R6 region7");
    access(15, 2, 1'b0, 1'b0, "R6 region15");

    // stores and minimal length
    cfg_write(16'h0000);
    access(8, 1, 1'b0, 1'b1, "R7 store window0");
    access(1, 0, 1'b0, 1'b1, "R7 store zero wait");

    // request during busy is ignored
    exp_q.push_back(acc_len(cfg_m, 12, 2, 1'b1, 1'b0));
    tag_q.push_back("R7 ignore busy req");
    @(negedge clk_i);
    req_i = 1'b1; region_i = 4'd12; width_i = 2'd2; seq_i = 1'b1; store_i = 1'b0;
    @(negedge clk_i);
    region_i = 4'd0; store_i = 1'b1; width_i = 2'd0; seq_i = 1'b0;
    repeat (3) @(negedge clk_i);
    req_i = 1'b0;
    wait_done();
    for (int i = 0; i < 3; i++) begin
      check(busy_o == 1'b0, "R7 no second access", int'(busy_o), 0);
      @(negedge clk_i);
    end

    // prefetch and burst, prefetch off then on
    cfg_write(16'h0000 | (2 << 2) | (1 << 4) | (3 << 5) | (0 << 8) | 2);
    comb_check(8,  1, 1,  "R9 pf w0 16 off", "R8 burst one");
    comb_check(10, 2, 4,  "R9 pf w1 32 off", "R8 burst four");
    comb_check(12, 2, 0,  "R9 pf w2 32 off", "R8 burst empty");
    comb_check(14, 2, 31, "R9 pf sram",      "R8 burst sram max");
    comb_check(2,  1, 3,  "R9 pf region2",   "R8 burst region2");
    comb_check(5,  2, 7,  "R9 pf region5",   "R8 burst zero region");
    cfg_write(cfg_m | 16'h4000);
    comb_check(9,  1, 2,  "R9 pf w0 on",     "R8 burst pf on");
    comb_check(11, 2, 5,  "R9 pf w1 on",     "R8 burst w1");
    comb_check(13, 2, 31, "R9 pf w2 on",     "R8 burst w2 max");
    comb_check(14, 1, 2,  "R9 pf sram on",   "R8 burst sram");

    // mirror pairs
    cfg_write(16'h0000 | (1 << 2) | (2 << 5) | (1 << 7) | (3 << 8));
    for (int p = 0; p < 3; p++) begin
      access(8 + 2*p, 2, 1'b0, 1'b0, "R10 pair base");
      access(9 + 2*p, 2, 1'b0, 1'b0, "R10 pair mirror");
      comb_check(9 + 2*p, 2, 6, "R10 mirror pf", "R10 mirror burst");
    end

    // config write during an access
    cfg_write(16'h0000);
    exp_q.push_back(acc_len(cfg_m, 8, 2, 1'b0, 1'b0));
    tag_q.push_back("R11 old timing kept");
    @(negedge clk_i);
    req_i = 1'b1; region_i = 4'd8; width_i = 2'd2; seq_i = 1'b0; store_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 16'h000C;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    cfg_m = 16'h000C;
    wait_done();
    access(8, 2, 1'b0, 1'b0, "R11 new timing next");

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R7 all accesses completed", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule